// File: doc/BRIEF.md
# Hierarchical Lookup-Table Neuron

This block computes one neuron of a quantized network with table reads and one adder stage. It uses no multiplier. The FAN_IN signed input codes, each IN_W bits wide, are split into groups of GROUP inputs. The codes of a group are joined side by side to form the address of that group's sub-table. The signed sub-table results are added together. The sum is clamped to the address range of a final table, and the clamped value selects the neuron's output code.

The host loads every table through a small write port before inference starts. After that, new input vectors may enter on every cycle. Each result leaves a fixed three cycles later, together with a valid flag. A write that arrives while any input vector is entering or is still inside the pipeline is dropped. Results that are already in flight therefore always see stable tables.

Top module: `lutn_neuron`

## Requirements
- R1: While `rstN` is low, and on the first cycle after it rises, `outValid` is 0 and `outCode` is 0.
- R2: Input i sits at bits `[i*IN_W +: IN_W]` of `inCodes`. Group g is made of inputs g*GROUP up to g*GROUP+GROUP-1. Its sub-table address is `inCodes[g*GROUP*IN_W +: GROUP*IN_W]`, so the lowest-numbered input of the group forms the least significant address bits.
- R3: Each sub-table entry is a signed SUB_W-bit value. The values read from all groups are added exactly, in two's complement, with no wrap.
- R4: The sum is clamped to the range -2^(FIN_AW-1) to 2^(FIN_AW-1)-1. The final-table address is the clamped value plus 2^(FIN_AW-1).
- R5: `outCode` is the signed IN_W-bit entry stored at that final-table address.
- R6: An input accepted with `inValid` high on clock edge k yields `outValid` high with its result after edge k+3. Back-to-back inputs give one result per cycle, in order.
- R7: A write is performed when `wrEn` is high and the pipeline is idle. `wrSel` equal to g (from 0 to NUM_GRP-1) writes sub-table g at `wrAddr[GROUP*IN_W-1:0]` with `wrData[SUB_W-1:0]`. `wrSel` equal to NUM_GRP writes the final table at `wrAddr[FIN_AW-1:0]` with `wrData[IN_W-1:0]`. Other `wrSel` values write nothing.
- R8: A write is dropped, leaving every table unchanged, if `inValid` is high or any earlier input has not yet produced its result.
- R9: `outCode` keeps its last value on cycles where `outValid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| inValid | input | 1 | An input vector is present on `inCodes` |
| inCodes | input | FAN_IN*IN_W | Packed signed input codes |
| wrEn | input | 1 | Table write request |
| wrSel | input | $clog2(NUM_GRP+1) | Target table: sub-table index, or NUM_GRP for the final table |
| wrAddr | input | max(GROUP*IN_W, FIN_AW) | Table entry address |
| wrData | input | max(SUB_W, IN_W) | Entry value |
| outValid | output | 1 | `outCode` carries a new result |
| outCode | output | IN_W | Signed neuron output code |

## Verification
The bench drives sums past both ends of the final-table range. A design that wraps the sum instead of clamping it would read a middle entry and give a wrong code. It also checks inputs that differ in only one group. A design that orders the group's address bits wrongly, or sign-extends the sub-table values wrongly, would read the wrong entries. It places writes in the cycle an input enters and while that input is still in flight. A design that accepts either write would return the overwritten entry when the same input is sent again later. Back-to-back streams check the exact three-cycle latency, and after the stream drains the bench checks that the last output is held.

// File: rtl/lutn_pkg.sv
`timescale 1ns/1ps
package lutn_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic wrGo;   // commit table write
    logic s1En;   // sub-table read stage
    logic s2En;   // adder stage
    logic s3En;   // final-table read stage
  } lutnStrobe_t;
endpackage

// File: rtl/lutn_ctrl.sv
`timescale 1ns/1ps
module lutn_ctrl
  import lutn_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        wrEn,
  output lutnStrobe_t strb,
  output logic        outValid
);
  logic v1, v2, v3;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
      v3 <= 1'b0;
    end else begin
      v1 <= inValid;
      v2 <= v1;
      v3 <= v2;
    end
  end

  always_comb begin
    strb.s1En = inValid;
    strb.s2En = v1;
    strb.s3En = v2;
    strb.wrGo = wrEn && !(inValid || v1 || v2 || v3);
  end

  assign outValid = v3;

  // R6
  lat_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(inValid, 3));
endmodule

// File: rtl/lutn_datapath.sv
`timescale 1ns/1ps
module lutn_datapath
  import lutn_pkg::*;
#(
  parameter int IN_W    = 2,
  parameter int FAN_IN  = 6,
  parameter int GROUP   = 3,
  parameter int SUB_W   = 4,
  parameter int FIN_AW  = 4,
  localparam int NUM_GRP   = FAN_IN / GROUP,
  localparam int GRP_AW    = GROUP * IN_W,
  localparam int SEL_W     = $clog2(NUM_GRP + 1),
  localparam int WR_AW     = (GRP_AW > FIN_AW) ? GRP_AW : FIN_AW,
  localparam int WR_DW     = (SUB_W > IN_W) ? SUB_W : IN_W
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  lutnStrobe_t              strb,
  input  logic [FAN_IN*IN_W-1:0]   inCodes,
  input  logic [SEL_W-1:0]         wrSel,
  input  logic [WR_AW-1:0]         wrAddr,
  input  logic [WR_DW-1:0]         wrData,
  output logic signed [IN_W-1:0]   outCode
);
  localparam int SUB_DEPTH = 1 << GRP_AW;
  localparam int FIN_DEPTH = 1 << FIN_AW;
  localparam int SUM_W     = SUB_W + $clog2(NUM_GRP) + 1;
  localparam logic signed [SUM_W-1:0] FIN_MAX_S = SUM_W'((2 ** (FIN_AW - 1)) - 1);
  localparam logic signed [SUM_W-1:0] FIN_MIN_S = SUM_W'(-(2 ** (FIN_AW - 1)));

  logic signed [SUB_W-1:0] subMem [NUM_GRP][SUB_DEPTH];
  logic signed [IN_W-1:0]  finMem [FIN_DEPTH];
  logic [GRP_AW-1:0]       grpAddr [NUM_GRP];
  logic signed [SUB_W-1:0] subQ [NUM_GRP];
  logic signed [SUM_W-1:0] sumC, sumQ, satV;
  logic [FIN_AW-1:0]       finAddr;

  // Address formation: each group's codes side by side
  for (genvar g = 0; g < NUM_GRP; g++) begin : gAddr
    assign grpAddr[g] = inCodes[g*GRP_AW +: GRP_AW];
  end

  // Table loading
  always_ff @(posedge clk) begin
    for (int g = 0; g < NUM_GRP; g++) begin
      if (strb.wrGo && wrSel == SEL_W'(g))
        subMem[g][wrAddr[GRP_AW-1:0]] <= wrData[SUB_W-1:0];
    end
    if (strb.wrGo && wrSel == SEL_W'(NUM_GRP))
      finMem[wrAddr[FIN_AW-1:0]] <= wrData[IN_W-1:0];
  end

  // Adder across groups, sign extended
  always_comb begin
    sumC = '0;
    for (int g = 0; g < NUM_GRP; g++)
      sumC = sumC + {{(SUM_W-SUB_W){subQ[g][SUB_W-1]}}, subQ[g]};
  end

  // Clamp to final-table range and offset into an address
  always_comb begin
    if (sumQ > FIN_MAX_S)      satV = FIN_MAX_S;
    else if (sumQ < FIN_MIN_S) satV = FIN_MIN_S;
    else                       satV = sumQ;
    finAddr = {~satV[FIN_AW-1], satV[FIN_AW-2:0]};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int g = 0; g < NUM_GRP; g++) subQ[g] <= '0;
      sumQ    <= '0;
      outCode <= '0;
    end else begin
      if (strb.s1En)
        for (int g = 0; g < NUM_GRP; g++) subQ[g] <= subMem[g][grpAddr[g]];
      if (strb.s2En) sumQ    <= sumC;
      if (strb.s3En) outCode <= finMem[finAddr];
    end
  end

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.s3En |=> $stable(outCode));

  // R4
  sat_hi_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.s3En && sumQ > FIN_MAX_S) |-> (finAddr == {FIN_AW{1'b1}}));

  // R4
  sat_lo_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.s3En && sumQ < FIN_MIN_S) |-> (finAddr == '0));

  // R8
  busy_wr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.s1En || strb.s2En || strb.s3En) |-> !strb.wrGo);
endmodule

// File: rtl/lutn_neuron.sv
`timescale 1ns/1ps
module lutn_neuron
  import lutn_pkg::*;
#(
  parameter int IN_W    = 2,
  parameter int FAN_IN  = 6,
  parameter int GROUP   = 3,
  parameter int SUB_W   = 4,
  parameter int FIN_AW  = 4,
  localparam int NUM_GRP = FAN_IN / GROUP,
  localparam int GRP_AW  = GROUP * IN_W,
  localparam int SEL_W   = $clog2(NUM_GRP + 1),
  localparam int WR_AW   = (GRP_AW > FIN_AW) ? GRP_AW : FIN_AW,
  localparam int WR_DW   = (SUB_W > IN_W) ? SUB_W : IN_W
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   inValid,
  input  logic [FAN_IN*IN_W-1:0] inCodes,
  input  logic                   wrEn,
  input  logic [SEL_W-1:0]       wrSel,
  input  logic [WR_AW-1:0]       wrAddr,
  input  logic [WR_DW-1:0]       wrData,
  output logic                   outValid,
  output logic signed [IN_W-1:0] outCode
);
  lutnStrobe_t strb;

  lutn_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .wrEn     (wrEn),
    .strb     (strb),
    .outValid (outValid)
  );

  lutn_datapath #(
    .IN_W   (IN_W),
    .FAN_IN (FAN_IN),
    .GROUP  (GROUP),
    .SUB_W  (SUB_W),
    .FIN_AW (FIN_AW)
  ) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .inCodes (inCodes),
    .wrSel   (wrSel),
    .wrAddr  (wrAddr),
    .wrData  (wrData),
    .outCode (outCode)
  );
endmodule

// File: tb/lutn_neuron_test.sv
`timescale 1ns/1ps
module lutn_neuron_test;
  localparam int NG  = 2;
  localparam int GAW = 6;
  localparam int FD  = 16;

  logic              clk = 1'b0;
  logic              rstN;
  logic              inValid;
  logic [11:0]       inCodes;
  logic              wrEn;
  logic [1:0]        wrSel;
  logic [5:0]        wrAddr;
  logic [3:0]        wrData;
  logic              outValid;
  logic signed [1:0] outCode;

  lutn_neuron uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inCodes(inCodes),
    .wrEn(wrEn), .wrSel(wrSel), .wrAddr(wrAddr), .wrData(wrData),
    .outValid(outValid), .outCode(outCode)
  );

  always #2.5 clk = ~clk;

  typedef struct { int val; int stamp; } item_t;
  item_t q[$];
  int subT [NG][64];
  int finT [FD];
  int cyc = 0;
  int nChk = 0;
  int nFail = 0;
  int lastOut = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string req, int act, int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic printSummary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
  endtask

  function automatic int finIdx(logic [11:0] c);
    int s = 0;
    for (int g = 0; g < NG; g++) s += subT[g][c[g*GAW +: GAW]];
    if (s > 7) s = 7;
    if (s < -8) s = -8;
    return s + 8;
  endfunction

  function automatic int expOut(logic [11:0] c);
    return finT[finIdx(c)];
  endfunction

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (q.size() == 0) begin
        chk(1'b0, "R6 result without input", 1, 0);
      end else begin
        item_t e;
        e = q.pop_front();
        chk(int'(outCode) == e.val, "R2/R3/R4/R5 output code", int'(outCode), e.val);
        chk(cyc == e.stamp + 3, "R6 latency", cyc - e.stamp, 3);
        lastOut = int'(outCode);
      end
    end
  end

  task automatic sendItem(logic [11:0] c);
    item_t e;
    inCodes = c;
    inValid = 1'b1;
    e.val = expOut(c);
    e.stamp = cyc;
    q.push_back(e);
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic writeTab(int sel, int addr, int data);
    wrEn = 1'b1;
    wrSel = 2'(sel);
    wrAddr = 6'(addr);
    wrData = 4'(data);
    @(negedge clk);
    wrEn = 1'b0;
    if (sel < NG) subT[sel][addr] = data;
    else finT[addr] = data;
  endtask

  task automatic drain();
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    printSummary();
    $finish;
  end

  initial begin
    logic [11:0] c;
    int idx;
    int nv;
    rstN = 1'b0; inValid = 1'b0; inCodes = '0;
    wrEn = 1'b0; wrSel = '0; wrAddr = '0; wrData = '0;
    repeat (3) @(negedge clk);
    // R1: during reset
    chk(outValid == 1'b0, "R1 outValid in reset", int'(outValid), 0);
    chk(outCode == 2'sd0, "R1 outCode in reset", int'(outCode), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(outValid == 1'b0, "R1 outValid after reset", int'(outValid), 0);
    chk(outCode == 2'sd0, "R1 outCode after reset", int'(outCode), 0);

    // R7: load all tables while idle
    for (int g = 0; g < NG; g++)
      for (int a = 0; a < 64; a++) writeTab(g, a, ((a * 5 + g * 3) % 16) - 8);
    for (int k = 0; k < FD; k++) writeTab(2, k, ((k * 3 + 1) % 4) - 2);

    // R2: patterns differing in one input / one group
    sendItem(12'h000);
    sendItem(12'h001);
    sendItem(12'h010);
    sendItem(12'h040);
    sendItem(12'h100);
    sendItem(12'h800);
    sendItem(12'hFFF);
    // R6: back-to-back stream
    for (int i = 0; i < 40; i++) sendItem(12'($urandom));
    drain();
    chk(q.size() == 0, "R6 all results returned", q.size(), 0);
    // R9: output held after the stream
    chk(int'(outCode) == lastOut, "R9 output held", int'(outCode), lastOut);
    @(negedge clk);
    chk(int'(outCode) == lastOut, "R9 output still held", int'(outCode), lastOut);

    // R4: clamp at both ends; a wrapped sum would pick entries 6 or 8
    writeTab(0, 63, 7);
    writeTab(1, 63, 7);
    writeTab(0, 0, -8);
    writeTab(1, 0, -8);
    writeTab(2, 15, 1);
    writeTab(2, 0, -2);
    writeTab(2, 6, -1);
    writeTab(2, 8, 0);
    sendItem(12'hFFF);
    drain();
    chk(lastOut == 1, "R4 clamp high", lastOut, 1);
    sendItem(12'h000);
    drain();
    chk(lastOut == -2, "R4 clamp low", lastOut, -2);

    // R8: writes while input enters and while in flight are dropped
    c = 12'h5A3;
    idx = finIdx(c);
    nv = (finT[idx] == 1) ? -2 : 1;
    begin
      item_t e;
      inCodes = c;
      inValid = 1'b1;
      e.val = expOut(c);
      e.stamp = cyc;
      q.push_back(e);
      wrEn = 1'b1; wrSel = 2'd2; wrAddr = 6'(idx); wrData = 4'(nv);
      @(negedge clk);
      inValid = 1'b0;
      @(negedge clk);
      @(negedge clk);
      wrEn = 1'b0;
    end
    drain();
    sendItem(c);
    drain();
    chk(lastOut == finT[idx], "R8 busy write dropped", lastOut, finT[idx]);

    // R7: same write while idle takes effect
    writeTab(2, idx, nv);
    sendItem(c);
    drain();
    chk(lastOut == nv, "R7 idle write applied", lastOut, nv);
    chk(q.size() == 0, "R6 queue empty at end", q.size(), 0);

    printSummary();
    $finish;
  end
endmodule